// File: doc/BRIEF.md
# Stateful Shared-Memory Access Monitor

This block checks every memory request that two soft processors make over a shared bus. The processors share an encryption engine, external DRAM and a debug window, and each also has its own I/O devices. An address decoder compares each request address against all windows at once. Some windows overlap: the three control words of the encryption engine sit inside the engine's first data window. Because of this, the decoder produces a multi-hot hit vector and not a single index.

A small policy state machine decides which processor currently owns the encryption engine. Ownership changes only when a processor performs a write-only access to one of two control words. A write to the claim word takes the engine from the free state. A write by the current owner to the release word gives it back. Read accesses never move the state machine. This keeps one processor from signalling to the other through read patterns that change state.

The grant and deny results are combinational, so they are valid in the same cycle as the request. Ownership changes take effect from the next request. No data flows through the block, so it has no valid/ready stream interface and applies no back-pressure. A request is a single-cycle strobe that is qualified by `req_valid`.

Top module: `access_policy_monitor`

## Requirements
- R1: After reset, `policy_state` is 2'b00 (free). Only 2'b00, 2'b01 (owned by master 0) and 2'b10 (owned by master 1) ever appear.
- R2: Master 0 (`req_master`=0) is granted reads and writes in 0x40600000–0x4060FFFF (serial port) and 0x24000000–0x24777777 (first DRAM window) in every state. Master 1 is denied in both windows.
- R3: Master 1 is granted reads and writes in 0x40C00000–0x40C0FFFF (network port) and 0x24800000–0x24FFFFFF (second DRAM window) in every state. Master 0 is denied in both windows.
- R4: Both masters are granted reads and writes in the debug window 0x41400000–0x4140FFFF in every state.
- R5: In the free state, all accesses by either master to the engine window 0x28000000–0x28000777 are denied. The only exception is the claim write of R6.
- R6: In the free state, a write-only request (`req_wr`=1, `req_rd`=0) by either master to the claim word 0x28000004–0x28000007 is granted. From the next cycle, the state is the owner state of that master.
- R7: In an owner state, the owner is granted reads and writes anywhere in 0x28000000–0x28000777, including the engine control word 0x28000000–0x28000003. The other master is denied there.
- R8: In an owner state, a write-only request by the owner to the release word 0x28000008–0x2800000F is granted. From the next cycle, the state is free.
- R9: A write to the claim or release word by the master that does not own the engine is denied, and the state does not change. The state never goes directly from one owner state to the other.
- R10: A request with `req_rd`=1, with or without `req_wr`, never changes the state.
- R11: A denied request leaves the state unchanged. Addresses in 0x28000800–0x28000FFF, in the gaps between windows, or outside every window are denied in all states.
- R12: `grant` and `deny` are combinational and never both high. With `req_valid` low, both are low. A valid request with neither strobe set is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 1 | Requesting master: 0 or 1 |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | 32 | Byte address of the request |
| grant | output | 1 | Request allowed (same cycle) |
| deny | output | 1 | Request refused (same cycle) |
| policy_state | output | 2 | Current ownership state |

## Verification
The `grant` and `deny` results are due in the same cycle as the request. The bench therefore holds each request from just after a rising edge and samples both outputs at the falling edge that follows. Any state change is due at the next rising edge. The bench reads `policy_state` one time unit after that edge, before it drives another request. The bench runs each probe address, master and strobe combination from each of the three states. It steers the state there first through the trigger writes, and those writes are checked as well.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int ADDR_W  = 32;
  localparam int MID_W   = 1;
  localparam int NUM_RNG = 10;

  typedef enum logic [1:0] {
    ST_FREE  = 2'b00,
    ST_OWN_A = 2'b01,
    ST_OWN_B = 2'b10
  } pol_state_e;

  // window indices in the hit vector
  localparam int RG_DEBUG   = 0;
  localparam int RG_ENG     = 1;
  localparam int RG_ENG_HI  = 2;
  localparam int RG_MEM_A   = 3;
  localparam int RG_MEM_B   = 4;
  localparam int RG_UART    = 5;
  localparam int RG_NET     = 6;
  localparam int RG_CW_CTRL = 7;
  localparam int RG_CW_CLM  = 8;
  localparam int RG_CW_REL  = 9;

  function automatic logic [ADDR_W-1:0] rng_lo(input int idx);
    case (idx)
      RG_DEBUG:   return 32'h4140_0000;
      RG_ENG:     return 32'h2800_0000;
      RG_ENG_HI:  return 32'h2800_0800;
      RG_MEM_A:   return 32'h2400_0000;
      RG_MEM_B:   return 32'h2480_0000;
      RG_UART:    return 32'h4060_0000;
      RG_NET:     return 32'h40C0_0000;
      RG_CW_CTRL: return 32'h2800_0000;
      RG_CW_CLM:  return 32'h2800_0004;
      default:    return 32'h2800_0008;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] rng_hi(input int idx);
    case (idx)
      RG_DEBUG:   return 32'h4140_FFFF;
      RG_ENG:     return 32'h2800_0777;
      RG_ENG_HI:  return 32'h2800_0FFF;
      RG_MEM_A:   return 32'h2477_7777;
      RG_MEM_B:   return 32'h24FF_FFFF;
      RG_UART:    return 32'h4060_FFFF;
      RG_NET:     return 32'h40C0_FFFF;
      RG_CW_CTRL: return 32'h2800_0003;
      RG_CW_CLM:  return 32'h2800_0007;
      default:    return 32'h2800_000F;
    endcase
  endfunction

  // rights every state grants, per master
  function automatic logic [NUM_RNG-1:0] base_mask(input logic [MID_W-1:0] mid);
    logic [NUM_RNG-1:0] m;
    m = '0;
    m[RG_DEBUG] = 1'b1;
    if (mid == '0) begin
      m[RG_UART]  = 1'b1;
      m[RG_MEM_A] = 1'b1;
    end else begin
      m[RG_NET]   = 1'b1;
      m[RG_MEM_B] = 1'b1;
    end
    return m;
  endfunction

  // extra rights held only by the current engine owner
  function automatic logic [NUM_RNG-1:0] owner_mask();
    logic [NUM_RNG-1:0] m;
    m = '0;
    m[RG_ENG]     = 1'b1;
    m[RG_CW_CTRL] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/apm_range_decode.sv
module apm_range_decode
  import apm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NR = NUM_RNG
) (
  input  logic [AW-1:0] addr,
  output logic [NR-1:0] hits
);
  // every window compared in parallel; overlapping windows give multi-hot hits
  for (genvar i = 0; i < NR; i++) begin : g_win
    localparam logic [AW-1:0] LO = rng_lo(i);
    localparam logic [AW-1:0] HI = rng_hi(i);
    assign hits[i] = (addr >= LO) && (addr <= HI);
  end
endmodule

// File: rtl/apm_rights.sv
module apm_rights
  import apm_pkg::*;
#(
  parameter int NR = NUM_RNG
) (
  input  pol_state_e       state,
  input  logic [MID_W-1:0] mid,
  input  logic             rd,
  input  logic             wr,
  input  logic [NR-1:0]    hits,
  output logic             allowed,
  output logic             claim,
  output logic             release_own
);
  logic is_owner;
  logic wr_only;

  always_comb begin
    is_owner = ((state == ST_OWN_A) && (mid == '0)) ||
               ((state == ST_OWN_B) && (mid != '0));
    wr_only  = wr && !rd;
    allowed  = (|(hits & base_mask(mid))) ||
               (is_owner && (|(hits & owner_mask())));
    claim       = (state == ST_FREE) && wr_only && hits[RG_CW_CLM];
    release_own = is_owner && wr_only && hits[RG_CW_REL];
  end
endmodule

// File: rtl/apm_policy_fsm.sv
module apm_policy_fsm
  import apm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             claim,
  input  logic             release_own,
  input  logic [MID_W-1:0] mid,
  output pol_state_e       state
);
  pol_state_e state_nx;

  always_comb begin
    state_nx = state;
    if (fire && claim)
      state_nx = (mid == '0) ? ST_OWN_A : ST_OWN_B;
    else if (fire && release_own)
      state_nx = ST_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FREE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/access_policy_monitor.sv
module access_policy_monitor
  import apm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NR = NUM_RNG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_master,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  output logic          grant,
  output logic          deny,
  output logic [1:0]    policy_state
);
  logic [NR-1:0] hits;
  logic          allowed, claim, release_own, any_strobe;
  pol_state_e    state;

  apm_range_decode #(.AW(AW), .NR(NR)) u_dec (
    .addr (req_addr),
    .hits (hits)
  );

  apm_rights #(.NR(NR)) u_rights (
    .state       (state),
    .mid         (req_master),
    .rd          (req_rd),
    .wr          (req_wr),
    .hits        (hits),
    .allowed     (allowed),
    .claim       (claim),
    .release_own (release_own)
  );

  apm_policy_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (req_valid),
    .claim       (claim),
    .release_own (release_own),
    .mid         (req_master),
    .state       (state)
  );

  assign any_strobe   = req_rd || req_wr;
  assign grant        = req_valid && any_strobe && (allowed || claim);
  assign deny         = req_valid && !grant;
  assign policy_state = state;
endmodule

// File: rtl/access_policy_monitor_chk.sv
module access_policy_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_master,
  input logic        req_rd,
  input logic        req_wr,
  input logic [31:0] req_addr,
  input logic        grant,
  input logic        deny,
  input logic [1:0]  policy_state
);
  logic claim_wr;
  assign claim_wr = req_valid && req_wr && !req_rd &&
                    (req_addr >= 32'h2800_0004) && (req_addr <= 32'h2800_0007);

  // R12
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(grant && deny));
  // R12
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !deny));
  // R1
  legal_chk: assert property (@(posedge clk) disable iff (!rst_n) policy_state != 2'b11);
  // R11
  deny_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && deny) |=> $stable(policy_state));
  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd) |=> $stable(policy_state));
  // R9
  no_swap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_state == 2'b01) |=> (policy_state != 2'b10));
  // R9
  no_swap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_state == 2'b10) |=> (policy_state != 2'b01));
  // R6
  claim_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_wr && policy_state == 2'b00) |=>
      (policy_state == ($past(req_master) ? 2'b10 : 2'b01)));
endmodule

bind access_policy_monitor access_policy_monitor_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_master   (req_master),
  .req_rd       (req_rd),
  .req_wr       (req_wr),
  .req_addr     (req_addr),
  .grant        (grant),
  .deny         (deny),
  .policy_state (policy_state)
);

// File: tb/access_policy_monitor_test.sv
module access_policy_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPROBE = 26;
  localparam logic [31:0] PROBES [NPROBE] = '{
    32'h4140_0000, 32'h4140_FFFF, 32'h413F_FFFF, 32'h2800_0000, 32'h2800_0003,
    32'h2800_0004, 32'h2800_000C, 32'h2800_0777, 32'h2800_0778, 32'h2800_0800,
    32'h2800_0FFF, 32'h2800_1000, 32'h2400_0000, 32'h2477_7777, 32'h2477_7778,
    32'h2480_0000, 32'h24FF_FFFF, 32'h2500_0000, 32'h4060_0000, 32'h4060_FFFF,
    32'h40C0_0000, 32'h40C0_FFFF, 32'h40C1_0000, 32'h0000_0000, 32'hFFFF_FFFF,
    32'h2800_0008
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_master = 1'b0;
  logic        req_rd = 1'b0;
  logic        req_wr = 1'b0;
  logic [31:0] req_addr = '0;
  logic        grant, deny;
  logic [1:0]  policy_state;

  int total = 0;
  int bad = 0;
  logic [1:0] mst = 2'b00;  // model state

  always #(CLK_PERIOD/2) clk = ~clk;

  access_policy_monitor uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_master(req_master),
    .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
    .grant(grant), .deny(deny), .policy_state(policy_state)
  );

  function automatic bit inr(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic bit is_own(logic [1:0] s, logic m);
    return (s == 2'b01 && !m) || (s == 2'b10 && m);
  endfunction

  function automatic bit base_ok(logic m, logic [31:0] a);
    if (inr(a, 32'h4140_0000, 32'h4140_FFFF)) return 1'b1;
    if (!m) return inr(a, 32'h4060_0000, 32'h4060_FFFF) || inr(a, 32'h2400_0000, 32'h2477_7777);
    return inr(a, 32'h40C0_0000, 32'h40C0_FFFF) || inr(a, 32'h2480_0000, 32'h24FF_FFFF);
  endfunction

  function automatic string why(logic [1:0] s, logic m, logic [31:0] a, logic rd, logic wr);
    if (!rd && !wr) return "R12";
    if (inr(a, 32'h4140_0000, 32'h4140_FFFF)) return "R4";
    if (inr(a, 32'h4060_0000, 32'h4060_FFFF) || inr(a, 32'h2400_0000, 32'h2477_7777)) return "R2";
    if (inr(a, 32'h40C0_0000, 32'h40C0_FFFF) || inr(a, 32'h2480_0000, 32'h24FF_FFFF)) return "R3";
    if (inr(a, 32'h2800_0000, 32'h2800_0777)) begin
      if (s == 2'b00) return (wr && !rd && inr(a, 32'h2800_0004, 32'h2800_0007)) ? "R6" : "R5";
      if (is_own(s, m)) return (wr && !rd && inr(a, 32'h2800_0008, 32'h2800_000F)) ? "R8" : "R7";
      return (wr && inr(a, 32'h2800_0004, 32'h2800_000F)) ? "R9" : "R7";
    end
    return "R11";
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_req(logic m, logic rd, logic wr, logic [31:0] a);
    bit claim_e, rel_e, g_e;
    logic [1:0] nst;
    string tag;
    @(posedge clk); #1;
    req_valid = 1'b1; req_master = m; req_rd = rd; req_wr = wr; req_addr = a;
    claim_e = (mst == 2'b00) && wr && !rd && inr(a, 32'h2800_0004, 32'h2800_0007);
    rel_e   = is_own(mst, m) && wr && !rd && inr(a, 32'h2800_0008, 32'h2800_000F);
    g_e = (rd || wr) && (base_ok(m, a) || claim_e ||
          (is_own(mst, m) && inr(a, 32'h2800_0000, 32'h2800_0777)));
    tag = why(mst, m, a, rd, wr);
    nst = claim_e ? (m ? 2'b10 : 2'b01) : (rel_e ? 2'b00 : mst);
    @(negedge clk);
    chk(grant == g_e && deny == !g_e, tag, "grant", int'(grant), int'(g_e));
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (claim_e || rel_e) tag = claim_e ? "R6" : "R8";
    else if (rd) tag = "R10";
    else if (!g_e) tag = "R11";
    chk(policy_state == nst, tag, "state", int'(policy_state), int'(nst));
    mst = nst;
  endtask

  task automatic goto_state(logic [1:0] t);
    if (mst != t && mst != 2'b00) do_req(mst == 2'b10, 1'b0, 1'b1, 32'h2800_0008);
    if (mst != t) do_req(t == 2'b10, 1'b0, 1'b1, 32'h2800_0004);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1: reset state
    chk(policy_state == 2'b00, "R1", "reset state", int'(policy_state), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: idle bus gives no result
    chk(!grant && !deny, "R12", "idle outputs", int'({grant, deny}), 0);
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < NPROBE; p++) begin
        for (int m = 0; m < 2; m++) begin
          for (int op = 0; op < 4; op++) begin
            goto_state(2'(s));
            do_req(m[0], op[0], op[1], PROBES[p]);
          end
        end
      end
    end
    // R9: non-owner trigger writes from each owner state
    goto_state(2'b01);
    do_req(1'b1, 1'b0, 1'b1, 32'h2800_0004);
    do_req(1'b1, 1'b0, 1'b1, 32'h2800_0008);
    goto_state(2'b10);
    do_req(1'b0, 1'b0, 1'b1, 32'h2800_000F);
    do_req(1'b0, 1'b0, 1'b1, 32'h2800_0007);
    goto_state(2'b00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule